// File: doc/BRIEF.md
# Shared-DAC Offset and Successive-Approximation Sequencer

This block sequences a two-channel, time-multiplexed analog front end. It uses a single DAC for two jobs. A frame-rate tick swaps the active channel. On each tick the block moves the mux select to the other channel and loads that channel's gain code. It also puts that channel's offset code on the DAC, so the analog chain can subtract the pedestal. The block then waits a fixed number of settling cycles and raises the sample-and-hold control, which freezes the comparator input.

Once the input is held, the same DAC runs a successive-approximation search. It tests one bit per cycle from the MSB down. A bit is kept when the comparator reports that the held signal is at or above the DAC level. The finished code leaves the block on a valid/ready output, tagged with its channel. A tick that arrives while the block is still settling or converting aborts that slot and raises an overrun pulse. The new slot then starts.

Result back-pressure works as follows. `res_valid` stays high, and `res_code` and `res_chan` stay constant, until `res_ready` is sampled high at a clock edge. `res_valid` drops in the next cycle unless a new result is captured at that same edge. A conversion never stalls. If a new code completes while an older one is still pending, the newer code replaces it.

Top module: `tdac_sar_seq`

## Requirements
- R1: While reset is asserted, the outputs take these values: `mux_sel`=1, `dac_code`=0, `gain_sel`=0, `hold`=0, `overrun`=0 and `res_valid`=0.
- R2: `mux_sel` toggles exactly once per tick and changes at no other time. The first tick after reset selects channel 0 (`mux_sel`=0). Channel 0 uses `off_a`/`gain_a` and channel 1 uses `off_b`/`gain_b`.
- R3: In the cycle after a tick, `dac_code` equals the new channel's offset and `gain_sel` equals its 2-bit gain code (four discrete gains). Changes to the offset or gain inputs after the tick have no effect on the outputs until the next tick.
- R4: For SETTLE_CYC cycles after the tick edge, `dac_code` holds the offset and `hold` stays 0. At the SETTLE_CYC-th edge `hold` goes to 1 and `dac_code` becomes the MSB-only trial code (0x800 at 12 bits).
- R5: Each following cycle resolves one bit, from the MSB down. A bit stays 1 when `cmp_hi`=1 (signal at or above the DAC) and the next lower bit is then set for trial. After DAC_W such cycles, that is SETTLE_CYC+DAC_W edges after the tick, `res_valid` rises. `res_code` then equals the final code and `res_chan` equals the converted channel.
- R6: While `res_valid`=1 and `res_ready`=0, `res_valid`, `res_code` and `res_chan` stay unchanged. When `res_ready` is sampled high and no new result is captured, `res_valid` is 0 in the next cycle.
- R7: A result that completes while an earlier one is still pending overwrites the earlier one.
- R8: A tick sampled while the block is settling or converting produces a one-cycle `overrun` pulse in the next cycle. That slot delivers no result, and the new slot starts normally. A tick interval of at least SETTLE_CYC+DAC_W+1 cycles never overruns.
- R9: After a conversion, `hold` stays 1 and `dac_code` keeps the final code until the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle channel-swap pulse at the frame rate |
| cmp_hi | input | 1 | Comparator: held signal at or above DAC level |
| off_a | input | DAC_W | Offset code, channel 0 |
| off_b | input | DAC_W | Offset code, channel 1 |
| gain_a | input | GAIN_W | Gain code, channel 0 |
| gain_b | input | GAIN_W | Gain code, channel 1 |
| dac_code | output | DAC_W | Shared DAC code |
| mux_sel | output | 1 | Active channel |
| gain_sel | output | GAIN_W | Gain select of the active channel |
| hold | output | 1 | Sample-and-hold control, 1 = hold |
| overrun | output | 1 | Slot aborted by an early tick (one-cycle pulse) |
| res_valid | output | 1 | Conversion result valid |
| res_ready | input | 1 | Consumer accepts the result |
| res_code | output | DAC_W | Converted code |
| res_chan | output | 1 | Channel of the converted code |

## Verification
Taking the tick edge as edge 0, several outputs change just after edge 0: the channel, gain and offset outputs, and the overrun pulse. The hold control and the MSB trial code appear after edge SETTLE_CYC, the result strobe after edge SETTLE_CYC+DAC_W, and a handshake takes effect one edge after the accepting edge. The bench keeps a behavioural model that counts edges since the last tick and derives every expected output from that count and the latched channel settings. It updates the model at each rising edge and compares every output at the following falling edge. Tick intervals of 40, 76 and 77 cycles place ticks just before and just after the last conversion edge.

// File: rtl/tdac_pkg.sv
package tdac_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_CONV   = 2'd2
  } phase_t;
endpackage

// File: rtl/tdac_slot_ctrl.sv
module tdac_slot_ctrl
  import tdac_pkg::*;
#(
  parameter int SETTLE_CYC = 64,
  parameter int GAIN_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              fin,
  input  logic [GAIN_W-1:0] gain_a,
  input  logic [GAIN_W-1:0] gain_b,
  output logic              chan,
  output logic [GAIN_W-1:0] gain_sel,
  output logic              hold,
  output logic              start,
  output logic              overrun
);
  localparam int CW = $clog2(SETTLE_CYC + 1);

  phase_t        phase;
  logic [CW-1:0] cnt;

  // Settling ends on the SETTLE_CYC-th edge after the tick edge.
  always_comb start = (phase == PH_SETTLE) && (cnt == CW'(SETTLE_CYC - 1)) && !tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      chan     <= 1'b1;
      gain_sel <= '0;
      hold     <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      overrun <= 1'b0;
      if (tick) begin
        overrun  <= (phase != PH_IDLE);
        chan     <= ~chan;
        gain_sel <= chan ? gain_a : gain_b;
        hold     <= 1'b0;
        cnt      <= '0;
        phase    <= PH_SETTLE;
      end else begin
        unique case (phase)
          PH_SETTLE: begin
            if (start) begin
              phase <= PH_CONV;
              hold  <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_CONV: if (fin) phase <= PH_IDLE;
          default: ;
        endcase
      end
    end
  end

  // R4: input is not frozen while the DAC still settles on the offset
  p_no_hold_settle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SETTLE) |-> !hold);
  // R2: channel moves only on a tick
  p_chan_only_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(chan));
  // R8: overrun pulse follows a tick
  p_ovr_after_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(tick));
endmodule

// File: rtl/tdac_sar_core.sv
module tdac_sar_core #(
  parameter int DAC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DAC_W-1:0] load_code,
  input  logic             start,
  input  logic             cmp_hi,
  output logic [DAC_W-1:0] dac,
  output logic             fin,
  output logic [DAC_W-1:0] fin_code
);
  localparam logic [DAC_W-1:0] MSB = {1'b1, {(DAC_W-1){1'b0}}};

  logic [DAC_W-1:0] mask;
  logic             busy;
  logic [DAC_W-1:0] kept;

  // Trial bit survives when the held signal is at or above the DAC level.
  always_comb begin
    kept     = cmp_hi ? dac : (dac & ~mask);
    fin      = busy && mask[0] && !load;
    fin_code = kept;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac  <= '0;
      mask <= '0;
      busy <= 1'b0;
    end else if (load) begin
      dac  <= load_code;
      mask <= '0;
      busy <= 1'b0;
    end else if (start) begin
      dac  <= MSB;
      mask <= MSB;
      busy <= 1'b1;
    end else if (busy) begin
      if (mask[0]) begin
        dac  <= kept;
        mask <= '0;
        busy <= 1'b0;
      end else begin
        dac  <= kept | (mask >> 1);
        mask <= mask >> 1;
      end
    end
  end

  // R5: exactly one bit under trial during a conversion
  p_one_trial_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(mask) == 1));
  // R9: DAC is quiet between conversion end and the next tick
  p_dac_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load && !start) |=> $stable(dac));
endmodule

// File: rtl/tdac_result_stage.sv
module tdac_result_stage #(
  parameter int DAC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [DAC_W-1:0] cap_code,
  input  logic             cap_chan,
  input  logic             res_ready,
  output logic             res_valid,
  output logic [DAC_W-1:0] res_code,
  output logic             res_chan
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_code  <= '0;
      res_chan  <= 1'b0;
    end else if (capture) begin
      res_valid <= 1'b1;
      res_code  <= cap_code;
      res_chan  <= cap_chan;
    end else if (res_valid && res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // R6: pending result held steady under back-pressure
  p_hold_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready && !capture) |=>
      (res_valid && $stable(res_code) && $stable(res_chan)));
endmodule

// File: rtl/tdac_sar_seq.sv
module tdac_sar_seq #(
  parameter int DAC_W      = 12,
  parameter int GAIN_W     = 2,
  parameter int SETTLE_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cmp_hi,
  input  logic [DAC_W-1:0]  off_a,
  input  logic [DAC_W-1:0]  off_b,
  input  logic [GAIN_W-1:0] gain_a,
  input  logic [GAIN_W-1:0] gain_b,
  output logic [DAC_W-1:0]  dac_code,
  output logic              mux_sel,
  output logic [GAIN_W-1:0] gain_sel,
  output logic              hold,
  output logic              overrun,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DAC_W-1:0]  res_code,
  output logic              res_chan
);
  logic             chan;
  logic             start;
  logic             fin;
  logic [DAC_W-1:0] fin_code;
  logic [DAC_W-1:0] next_off;

  // Offset of the channel about to become active.
  always_comb next_off = chan ? off_a : off_b;
  always_comb mux_sel  = chan;

  tdac_slot_ctrl #(.SETTLE_CYC(SETTLE_CYC), .GAIN_W(GAIN_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fin(fin),
    .gain_a(gain_a), .gain_b(gain_b),
    .chan(chan), .gain_sel(gain_sel), .hold(hold),
    .start(start), .overrun(overrun)
  );

  tdac_sar_core #(.DAC_W(DAC_W)) u_sar (
    .clk(clk), .rst_n(rst_n), .load(tick), .load_code(next_off),
    .start(start), .cmp_hi(cmp_hi),
    .dac(dac_code), .fin(fin), .fin_code(fin_code)
  );

  tdac_result_stage #(.DAC_W(DAC_W)) u_res (
    .clk(clk), .rst_n(rst_n), .capture(fin), .cap_code(fin_code),
    .cap_chan(chan), .res_ready(res_ready),
    .res_valid(res_valid), .res_code(res_code), .res_chan(res_chan)
  );
endmodule

// File: tb/tb_tdac_sar_seq.sv
module tb_tdac_sar_seq;
  localparam int W = 12;
  localparam int G = 2;
  localparam int S = 64;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n = 1'b0, tick = 1'b0, cmp_hi, res_ready = 1'b1;
  logic [W-1:0] off_a = '0, off_b = '0;
  logic [G-1:0] gain_a = '0, gain_b = '0;
  logic [W-1:0] dac_code, res_code;
  logic [G-1:0] gain_sel;
  logic         mux_sel, hold, overrun, res_valid, res_chan;
  int           tgt0 = 0, tgt1 = 0;
  int           tests = 0, fails = 0;
  bit           go = 0;

  tdac_sar_seq #(.DAC_W(W), .GAIN_W(G), .SETTLE_CYC(S)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmp_hi(cmp_hi),
    .off_a(off_a), .off_b(off_b), .gain_a(gain_a), .gain_b(gain_b),
    .dac_code(dac_code), .mux_sel(mux_sel), .gain_sel(gain_sel),
    .hold(hold), .overrun(overrun), .res_valid(res_valid),
    .res_ready(res_ready), .res_code(res_code), .res_chan(res_chan)
  );

  // Comparator model: held signal at or above the DAC level.
  always_comb cmp_hi = ((mux_sel ? tgt1 : tgt0) >= int'(dac_code));

  // Behavioural reference: edges since the last tick plus latched settings.
  int m_t = -1, m_chan = 1, m_gain = 0, m_off = 0, m_tgt = 0;
  int m_valid = 0, m_code = 0, m_rch = 0, m_ovr = 0, tp;
  bit m_fin;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_t = -1; m_chan = 1; m_gain = 0; m_off = 0; m_valid = 0; m_ovr = 0;
    end else begin
      tp    = m_t;
      m_ovr = 0;
      m_fin = !tick && (tp == S + W - 1);
      if (tick) begin
        m_ovr  = (tp >= 0 && tp <= S + W - 1) ? 1 : 0;
        m_chan = 1 - m_chan;
        m_gain = m_chan ? int'(gain_b) : int'(gain_a);
        m_off  = m_chan ? int'(off_b) : int'(off_a);
        m_tgt  = m_chan ? tgt1 : tgt0;
        m_t    = 0;
      end else if (m_t >= 0) begin
        m_t++;
      end
      if (m_fin) begin
        m_valid = 1; m_code = m_tgt; m_rch = m_chan;
      end else if (m_valid != 0 && res_ready) begin
        m_valid = 0;
      end
    end
  end

  function automatic int exp_dac(int t, int off, int tg);
    int j;
    if (t < 0) return 0;
    if (t < S) return off;
    j = t - S;
    if (j >= W) return tg;
    return (tg & ~((1 << (W - j)) - 1)) | (1 << (W - 1 - j));
  endfunction

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (go) begin
      chk("R2 mux_sel", int'(mux_sel), m_chan);
      chk("R3 gain_sel", int'(gain_sel), m_gain);
      chk("R3/R4/R5 dac_code", int'(dac_code), exp_dac(m_t, m_off, m_tgt));
      chk("R4/R9 hold", int'(hold), (m_t >= S) ? 1 : 0);
      chk("R8 overrun", int'(overrun), m_ovr);
      chk("R6 res_valid", int'(res_valid), m_valid);
      if (m_valid != 0) begin
        chk("R5/R7 res_code", int'(res_code), m_code);
        chk("R5 res_chan", int'(res_chan), m_rch);
      end
    end
  end

  task automatic slot(int n, int a, int b);
    @(negedge clk);
    tgt0 = a; tgt1 = b; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    repeat (n - 2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    off_a = 12'h300; off_b = 12'h455; gain_a = 2'd1; gain_b = 2'd2;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 mux_sel", int'(mux_sel), 1);
    chk("R1 dac_code", int'(dac_code), 0);
    chk("R1 gain_sel", int'(gain_sel), 0);
    chk("R1 hold", int'(hold), 0);
    chk("R1 overrun", int'(overrun), 0);
    chk("R1 res_valid", int'(res_valid), 0);
    rst_n = 1'b1;
    go = 1;
    repeat (4) @(negedge clk);
    slot(100, 'hA5C, 'h123);
    slot(100, 'hA5C, 'h123);
    // R3: inputs changed mid-slot must not reach the outputs
    @(negedge clk); tgt0 = 0; tgt1 = 4095; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    repeat (10) @(negedge clk);
    off_a = 12'h111; off_b = 12'hEEE; gain_a = 2'd3; gain_b = 2'd0;
    repeat (88) @(negedge clk);
    slot(100, 0, 4095);
    // R6/R7: back-pressure, then overwrite of a pending result
    res_ready = 1'b0;
    slot(100, 'h800, 'h7FF);
    slot(100, 'h800, 'h7FF);
    repeat (5) @(negedge clk);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    slot(100, 1, 'hFFE);
    repeat (3) @(negedge clk);
    res_ready = 1'b1;
    slot(100, 1, 'hFFE);
    // R8: early ticks around the last conversion edge
    slot(40, 'h5A5, 'h3C3);
    slot(76, 'h5A5, 'h3C3);
    slot(77, 'h5A5, 'h3C3);
    slot(77, 'h2B7, 'hD19);
    slot(100, 'h2B7, 'hD19);
    slot(100, 'h001, 'h800);
    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule